// File: doc/BRIEF.md
# Serial-Bus Voice Memory Command Sequencer

This block is the command layer of a voice-memory device that sits on a byte-oriented two-wire serial bus. A separate front end handles bit timing. It hands this block each received byte, together with a flag that marks the first byte after a start or repeated start. It also passes a pulse for the falling edge of the slave acknowledge, a pulse for each stop condition, and a pulse each time the master takes a byte in read direction.

A write frame carries the device address byte, a command byte and, for the opcodes that need one, a high address byte and then a low address byte. The sequencer decodes the opcode, tracks power and digital mode, and drives one-cycle start strobes toward the array with the row address. A read frame returns either a status byte followed by the row address, or, right after an accepted digital read command, hands the byte stream over to the array. Overflow and end-of-message events set a latched, active-low interrupt that is released when the status byte is read.

Top module: `vmem_cmd_seq`

## Requirements
- R1: After reset, int_n is 1, powered and dig_mode are 0, and no strobe is active.
- R2: A frame is selected by a first byte of 0x80 (write) or 0x81 (read). Each command executes on the ack_fall that follows its final byte. For opcodes 0x91, 0xD1, 0xC9 and 0xE1 the final byte is the low address byte; for all other opcodes it is the command byte. The row address is {high byte, low byte}.
- R3: Opcode 0x80 sets powered and pulses stop_stb.
- R4: Opcode 0xC0 sets dig_mode and opcode 0x40 clears it.
- R5: Opcode 0x91 pulses rec_stb and loads row_addr, whether or not dig_mode is set.
- R6: Opcodes 0xD1, 0xC9 and 0xE1 pulse erase_stb, wr_stb and rd_stb respectively, but only while dig_mode is 1. Otherwise they produce no strobe and set the error status bit; unknown opcodes also set the error bit.
- R7: For an erase, row_addr has its lowest PAGE_LSB bits forced to zero (5 by default), so erases land on a row boundary.
- R8: A bus_stop that arrives before the final acknowledge of a command aborts it: no strobe fires and no state changes.
- R9: A frame whose first byte is neither 0x80 nor 0x81 is ignored entirely.
- R10: An ovf_evt or eom_evt pulse drives int_n low from the next cycle, and int_n stays low until the status byte is read.
- R11: In a read frame (when no digital read is pending), tx_byte returns the status byte, then row_addr[15:8], then row_addr[7:0]. The status byte is {ovf, eom, err, dig_mode, powered, 3'b000}, MSB first. Popping the status byte clears ovf, eom and err and releases int_n.
- R12: After an accepted 0xE1, the next read frame sets tx_from_array to 1 and leaves the status bits untouched. Any new write-address byte cancels the pending digital read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_start | input | 1 | This byte is the first after a start or repeated start |
| ack_fall | input | 1 | Falling edge of the slave acknowledge |
| bus_stop | input | 1 | Stop condition seen |
| tx_pop | input | 1 | Master has taken the current read-direction byte |
| ovf_evt | input | 1 | Array overflow event |
| eom_evt | input | 1 | End-of-message event |
| tx_byte | output | 8 | Byte offered for read direction |
| tx_from_array | output | 1 | Read data comes from the array rather than status |
| powered | output | 1 | Device powered up |
| dig_mode | output | 1 | Digital mode active |
| row_addr | output | 16 | Row address for the array |
| stop_stb | output | 1 | Stop/power-up strobe |
| rec_stb | output | 1 | Analog record start strobe |
| erase_stb | output | 1 | Digital page erase strobe |
| wr_stb | output | 1 | Digital write start strobe |
| rd_stb | output | 1 | Digital read start strobe |
| int_n | output | 1 | Open-drain style interrupt, low when active |

## Verification
The bench uses the default parameters: device address 0x40 (so 0x80 and 0x81 on the bus), a 5-bit page offset and 16-bit rows. With these values, a low address byte of 0xCD reveals whether the erase masking clears exactly five bits (expected 0xC0). They also let the status bytes be compared against fixed values such as 0xB8 and 0x58, which exercise every status bit position.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  localparam logic [7:0] OP_PWR     = 8'h80;
  localparam logic [7:0] OP_DIG_ON  = 8'hC0;
  localparam logic [7:0] OP_DIG_OFF = 8'h40;
  localparam logic [7:0] OP_REC     = 8'h91;
  localparam logic [7:0] OP_ERASE   = 8'hD1;
  localparam logic [7:0] OP_WR      = 8'hC9;
  localparam logic [7:0] OP_RD      = 8'hE1;

  typedef enum logic [2:0] {
    FR_IDLE, FR_CMD, FR_HI, FR_LO, FR_ARM, FR_TAIL, FR_RD
  } fr_state_t;

  function automatic logic needs_addr(input logic [7:0] op);
    return (op == OP_REC) || (op == OP_ERASE) || (op == OP_WR) || (op == OP_RD);
  endfunction
endpackage

// File: rtl/vmem_frame.sv
module vmem_frame
  import vmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_start,
  input  logic             ack_fall,
  input  logic             bus_stop,
  input  logic             tx_pop,
  output logic             go,
  output logic [7:0]       opc,
  output logic [ROW_W-1:0] row,
  output logic             in_rd,
  output logic [1:0]       tx_idx,
  output logic             wr_seen,
  output logic             rd_seen
);
  fr_state_t  st;
  logic [7:0] hi_q, lo_q;

  assign wr_seen = rx_valid && rx_start && (rx_byte == {DEV_ADDR, 1'b0});
  assign rd_seen = rx_valid && rx_start && (rx_byte == {DEV_ADDR, 1'b1});
  assign row     = ROW_W'({hi_q, lo_q});
  assign in_rd   = (st == FR_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FR_IDLE; go <= 1'b0; opc <= '0;
      hi_q <= '0; lo_q <= '0; tx_idx <= '0;
    end else begin
      go <= 1'b0;
      if (bus_stop) begin
        st <= FR_IDLE;
      end else if (rx_valid && rx_start) begin
        tx_idx <= '0;
        if (wr_seen)      st <= FR_CMD;
        else if (rd_seen) st <= FR_RD;
        else              st <= FR_IDLE;
      end else if (rx_valid) begin
        case (st)
          FR_CMD: begin
            opc <= rx_byte;
            st  <= needs_addr(rx_byte) ? FR_HI : FR_ARM;
          end
          FR_HI: begin hi_q <= rx_byte; st <= FR_LO;  end
          FR_LO: begin lo_q <= rx_byte; st <= FR_ARM; end
          default: ;
        endcase
      end else if (ack_fall && st == FR_ARM) begin
        go <= 1'b1;
        st <= FR_TAIL;
      end else if (tx_pop && st == FR_RD && tx_idx != 2'd3) begin
        tx_idx <= tx_idx + 2'd1;
      end
    end
  end

  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !go);
  p_go_once_r2: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);
endmodule

// File: rtl/vmem_exec.sv
module vmem_exec
  import vmem_pkg::*;
#(
  parameter int ROW_W    = 16,
  parameter int PAGE_LSB = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [7:0]       opc,
  input  logic [ROW_W-1:0] row,
  input  logic             wr_seen,
  input  logic             rd_seen,
  output logic             powered,
  output logic             dig_mode,
  output logic [ROW_W-1:0] row_addr,
  output logic             stop_stb,
  output logic             rec_stb,
  output logic             erase_stb,
  output logic             wr_stb,
  output logic             rd_stb,
  output logic             err_set,
  output logic             serve_array
);
  localparam logic [ROW_W-1:0] PAGE_MASK = ~((ROW_W'(1) << PAGE_LSB) - ROW_W'(1));
  logic rd_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      powered <= 1'b0; dig_mode <= 1'b0; row_addr <= '0;
      stop_stb <= 1'b0; rec_stb <= 1'b0; erase_stb <= 1'b0;
      wr_stb <= 1'b0; rd_stb <= 1'b0; err_set <= 1'b0;
      rd_armed <= 1'b0; serve_array <= 1'b0;
    end else begin
      stop_stb <= 1'b0; rec_stb <= 1'b0; erase_stb <= 1'b0;
      wr_stb <= 1'b0; rd_stb <= 1'b0; err_set <= 1'b0;
      if (wr_seen) rd_armed <= 1'b0;
      if (rd_seen) serve_array <= rd_armed;
      if (go) begin
        case (opc)
          OP_PWR:     begin powered <= 1'b1; stop_stb <= 1'b1; end
          OP_DIG_ON:  dig_mode <= 1'b1;
          OP_DIG_OFF: dig_mode <= 1'b0;
          OP_REC:     begin rec_stb <= 1'b1; row_addr <= row; end
          OP_ERASE, OP_WR, OP_RD: begin
            if (!dig_mode) begin
              err_set <= 1'b1;
            end else begin
              row_addr  <= (opc == OP_ERASE) ? (row & PAGE_MASK) : row;
              erase_stb <= (opc == OP_ERASE);
              wr_stb    <= (opc == OP_WR);
              rd_stb    <= (opc == OP_RD);
              if (opc == OP_RD) rd_armed <= 1'b1;
            end
          end
          default: err_set <= 1'b1;
        endcase
      end
    end
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stop_stb, rec_stb, erase_stb, wr_stb, rd_stb}));
  p_dig_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (erase_stb || wr_stb || rd_stb) |-> $past(dig_mode));
  p_row_align_r7: assert property (@(posedge clk) disable iff (rst)
    erase_stb |-> (row_addr[PAGE_LSB-1:0] == '0));
  p_power_r3: assert property (@(posedge clk) disable iff (rst)
    stop_stb |-> powered);
endmodule

// File: rtl/vmem_status.sv
module vmem_status #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf_evt,
  input  logic             eom_evt,
  input  logic             err_set,
  input  logic             in_rd,
  input  logic             serve_array,
  input  logic [1:0]       tx_idx,
  input  logic             tx_pop,
  input  logic             dig_mode,
  input  logic             powered,
  input  logic [ROW_W-1:0] row_addr,
  output logic [7:0]       tx_byte,
  output logic             tx_from_array,
  output logic             int_n
);
  logic ovf_l, eom_l, err_l, clr;
  logic [15:0] row16;

  assign row16         = 16'(row_addr);
  assign tx_from_array = in_rd && serve_array;
  assign clr           = tx_pop && in_rd && !serve_array && (tx_idx == 2'd0);
  assign int_n         = !(ovf_l || eom_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_l <= 1'b0; eom_l <= 1'b0; err_l <= 1'b0;
    end else begin
      ovf_l <= ovf_evt || (ovf_l && !clr);
      eom_l <= eom_evt || (eom_l && !clr);
      err_l <= err_set || (err_l && !clr);
    end
  end

  always_comb begin
    case (tx_idx)
      2'd0:    tx_byte = {ovf_l, eom_l, err_l, dig_mode, powered, 3'b000};
      2'd1:    tx_byte = row16[15:8];
      2'd2:    tx_byte = row16[7:0];
      default: tx_byte = 8'hFF;
    endcase
  end

  p_int_set_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt || eom_evt) |=> !int_n);
  p_int_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!int_n && !clr) |=> !int_n);
  p_int_release_r11: assert property (@(posedge clk) disable iff (rst)
    (clr && !ovf_evt && !eom_evt) |=> int_n);
endmodule

// File: rtl/vmem_cmd_seq.sv
module vmem_cmd_seq
  import vmem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int ROW_W    = 16,
  parameter int PAGE_LSB = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_start,
  input  logic             ack_fall,
  input  logic             bus_stop,
  input  logic             tx_pop,
  input  logic             ovf_evt,
  input  logic             eom_evt,
  output logic [7:0]       tx_byte,
  output logic             tx_from_array,
  output logic             powered,
  output logic             dig_mode,
  output logic [ROW_W-1:0] row_addr,
  output logic             stop_stb,
  output logic             rec_stb,
  output logic             erase_stb,
  output logic             wr_stb,
  output logic             rd_stb,
  output logic             int_n
);
  logic             go, in_rd, wr_seen, rd_seen, err_set, serve_array;
  logic [7:0]       opc;
  logic [ROW_W-1:0] row;
  logic [1:0]       tx_idx;

  vmem_frame #(.DEV_ADDR(DEV_ADDR), .ROW_W(ROW_W)) u_frame (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_start(rx_start), .ack_fall(ack_fall), .bus_stop(bus_stop),
    .tx_pop(tx_pop), .go(go), .opc(opc), .row(row), .in_rd(in_rd),
    .tx_idx(tx_idx), .wr_seen(wr_seen), .rd_seen(rd_seen));

  vmem_exec #(.ROW_W(ROW_W), .PAGE_LSB(PAGE_LSB)) u_exec (
    .clk(clk), .rst(rst), .go(go), .opc(opc), .row(row),
    .wr_seen(wr_seen), .rd_seen(rd_seen), .powered(powered),
    .dig_mode(dig_mode), .row_addr(row_addr), .stop_stb(stop_stb),
    .rec_stb(rec_stb), .erase_stb(erase_stb), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .err_set(err_set), .serve_array(serve_array));

  vmem_status #(.ROW_W(ROW_W)) u_status (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .eom_evt(eom_evt),
    .err_set(err_set), .in_rd(in_rd), .serve_array(serve_array),
    .tx_idx(tx_idx), .tx_pop(tx_pop), .dig_mode(dig_mode),
    .powered(powered), .row_addr(row_addr), .tx_byte(tx_byte),
    .tx_from_array(tx_from_array), .int_n(int_n));
endmodule

// File: tb/vmem_cmd_seq_bench.sv
module vmem_cmd_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_start = 1'b0, ack_fall = 1'b0, bus_stop = 1'b0;
  logic tx_pop = 1'b0, ovf_evt = 1'b0, eom_evt = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_byte;
  logic [15:0] row_addr;
  logic tx_from_array, powered, dig_mode, int_n;
  logic stop_stb, rec_stb, erase_stb, wr_stb, rd_stb;

  always #2 clk = ~clk;

  vmem_cmd_seq u_vmem_cmd_seq (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_start(rx_start), .ack_fall(ack_fall), .bus_stop(bus_stop),
    .tx_pop(tx_pop), .ovf_evt(ovf_evt), .eom_evt(eom_evt),
    .tx_byte(tx_byte), .tx_from_array(tx_from_array), .powered(powered),
    .dig_mode(dig_mode), .row_addr(row_addr), .stop_stb(stop_stb),
    .rec_stb(rec_stb), .erase_stb(erase_stb), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .int_n(int_n));

  int n_chk = 0, n_bad = 0, n_strobe = 0;
  logic [2:0] last_kind = 3'd0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (stop_stb)  begin n_strobe++; last_kind <= 3'd1; end
    if (rec_stb)   begin n_strobe++; last_kind <= 3'd2; end
    if (erase_stb) begin n_strobe++; last_kind <= 3'd3; end
    if (wr_stb)    begin n_strobe++; last_kind <= 3'd4; end
    if (rd_stb)    begin n_strobe++; last_kind <= 3'd5; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input logic first);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_start = first;
    @(negedge clk); rx_valid = 1'b0; rx_start = 1'b0; ack_fall = 1'b1;
    @(negedge clk); ack_fall = 1'b0;
  endtask

  task automatic put_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop();
    tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
  endtask

  function automatic bit has_addr(input logic [7:0] op);
    return op == 8'h91 || op == 8'hD1 || op == 8'hC9 || op == 8'hE1;
  endfunction

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [2:0]  kind;
    logic        dig;
    logic [15:0] row;
  } vec_t;

  // kind: 0 none, 1 stop, 2 record, 3 erase, 4 write, 5 read
  localparam vec_t VEC [9] = '{
    '{8'h91, 8'h12, 8'h34, 3'd2, 1'b0, 16'h1234},
    '{8'hD1, 8'h22, 8'h33, 3'd0, 1'b0, 16'h0000},
    '{8'h80, 8'h00, 8'h00, 3'd1, 1'b0, 16'h0000},
    '{8'hC0, 8'h00, 8'h00, 3'd0, 1'b1, 16'h0000},
    '{8'hD1, 8'hAB, 8'hCD, 3'd3, 1'b1, 16'hABC0},
    '{8'hC9, 8'h01, 8'h02, 3'd4, 1'b1, 16'h0102},
    '{8'h91, 8'h55, 8'h7F, 3'd2, 1'b1, 16'h557F},
    '{8'h40, 8'h00, 8'h00, 3'd0, 1'b0, 16'h0000},
    '{8'hC9, 8'h07, 8'h07, 3'd0, 1'b0, 16'h0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1; n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 int_n", int_n, 1);
    check("R1 powered", powered, 0);
    check("R1 dig_mode", dig_mode, 0);
    check("R1 strobes", n_strobe, 0);

    // R2..R7 command table
    for (int i = 0; i < 9; i++) begin
      base = n_strobe;
      put_byte(8'h80, 1'b1);
      put_byte(VEC[i].op, 1'b0);
      if (has_addr(VEC[i].op)) begin
        put_byte(VEC[i].hi, 1'b0);
        put_byte(VEC[i].lo, 1'b0);
      end
      put_stop();
      check("R2/R6 strobe count", n_strobe - base, (VEC[i].kind != 0) ? 1 : 0);
      if (VEC[i].kind != 0) check("R2/R3/R5/R7 kind", last_kind, VEC[i].kind);
      if (VEC[i].kind >= 2) check("R2/R7 row", row_addr, VEC[i].row);
      check("R4 dig_mode", dig_mode, VEC[i].dig);
    end
    check("R3 powered", powered, 1);

    // R8 abort: stop before low byte, and after low byte before its ack
    base = n_strobe;
    put_byte(8'h80, 1'b1); put_byte(8'h91, 1'b0); put_byte(8'h66, 1'b0);
    put_stop();
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h80; rx_start = 1'b1;
    @(negedge clk); rx_byte = 8'h91; rx_start = 1'b0;
    @(negedge clk); rx_byte = 8'h66;
    @(negedge clk); rx_byte = 8'h77;
    @(negedge clk); rx_valid = 1'b0;
    put_stop();
    put_byte(8'h00, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 no strobe", n_strobe - base, 0);
    check("R8 row kept", row_addr, 16'h557F);

    // R9 frame for another device
    base = n_strobe;
    put_byte(8'h90, 1'b1); put_byte(8'h80, 1'b0);
    put_byte(8'hC0, 1'b0);
    put_stop();
    check("R9 ignored strobes", n_strobe - base, 0);
    check("R9 ignored dig", dig_mode, 0);

    // R12 digital read hand-over
    put_byte(8'h80, 1'b1); put_byte(8'hC0, 1'b0); put_stop();
    base = n_strobe;
    put_byte(8'h80, 1'b1); put_byte(8'hE1, 1'b0);
    put_byte(8'h00, 1'b0); put_byte(8'h40, 1'b0);
    repeat (2) @(negedge clk);
    check("R12 rd strobe", n_strobe - base, 1);
    check("R12 rd kind", last_kind, 3'd5);
    put_byte(8'h81, 1'b1);
    check("R12 from array", tx_from_array, 1);
    pop();
    put_stop();
    put_byte(8'h80, 1'b1); put_stop();

    // R10 interrupt latch
    @(negedge clk); ovf_evt = 1'b1;
    @(negedge clk); ovf_evt = 1'b0;
    check("R10 int low", int_n, 0);
    repeat (5) @(negedge clk);
    check("R10 int held", int_n, 0);

    // R11 status read: {ovf,eom,err,dig,pwr,000}
    put_byte(8'h81, 1'b1);
    check("R12 status served", tx_from_array, 0);
    check("R11 status byte", tx_byte, 8'hB8);
    pop();
    check("R11 int released", int_n, 1);
    check("R11 row hi", tx_byte, 8'h00);
    pop();
    check("R11 row lo", tx_byte, 8'h40);
    pop();
    put_stop();
    put_byte(8'h81, 1'b1);
    check("R11 status cleared", tx_byte, 8'h18);
    put_stop();

    // R10/R11 end of message
    @(negedge clk); eom_evt = 1'b1;
    @(negedge clk); eom_evt = 1'b0;
    check("R10 eom int", int_n, 0);
    put_byte(8'h81, 1'b1);
    check("R11 eom status", tx_byte, 8'h58);
    pop();
    check("R11 eom released", int_n, 1);
    put_stop();

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule